// File: doc/BRIEF.md
# Packet Stream to GMII Transmit Adapter

This block turns an 8-bit packet stream into gigabit media-independent interface (GMII) transmit signalling. The stream side gives one byte per cycle with valid and ready handshaking, and marks each packet with start and end flags. An error flag is sampled only on the final byte. The GMII side has a transmit enable, an 8-bit data bus and a transmit error line. All three are registered on the rising edge of the transmit clock, so the GMII side lags the stream by exactly one cycle.

The enable line frames each packet. It rises with the first byte and stays high with no gaps until the last byte is on the bus. Three events mark a frame as bad, and each sets the error line on the frame's final byte: an error flag on the end byte, a stall in the middle of a frame, or a new start flag that arrives before the current frame has ended. A stall inside a frame does not break the enable. A fill byte is sent in its place and the frame is marked as bad. After every frame, ready is held low for a fixed number of cycles, so frames on the line are separated by a minimum idle gap.

Top module: `pgt_tx_adapter`

## Requirements
- R1: After reset, gmii_tx_en and gmii_tx_er are 0, gmii_txd is 8'h00 and in_ready is 1.
- R2: A byte accepted at a rising edge (in_valid and in_ready both high) appears on gmii_txd with gmii_tx_en high in the clock cycle that follows that edge.
- R3: gmii_tx_en rises only with a byte that carries in_sop. It then stays high every cycle until the frame's final byte has been driven, and it is low at all other times.
- R4: A byte accepted with in_sop low while no frame is open is discarded, and gmii_tx_en stays low.
- R5: gmii_tx_er is high only in the cycle that carries a frame's final byte, and only when that frame is bad. A frame is bad when in_err was high on its in_eop byte, or when R7 or R8 applies.
- R6: After a frame's final byte is accepted, in_ready is low for exactly GAP_CYCLES cycles (default 12). gmii_tx_en is then low for at least GAP_CYCLES cycles between frames, and for exactly that many when the next frame is offered at once.
- R7: If in_valid is low in a cycle while a frame is open, gmii_tx_en stays high and the fill byte (FILL_BYTE, default 8'h00, when FILL_MODE is 0) is sent. The frame is then bad.
- R8: A byte with in_sop high that is accepted while a frame is open is sent as that frame's final byte with gmii_tx_er high, and the gap of R6 follows. Later bytes without in_sop are discarded as in R4.
- R9: A byte with both in_sop and in_eop high (and no frame open) forms a one-byte frame. gmii_tx_en is high for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 8 | Stream byte |
| in_valid | input | 1 | Stream byte is present |
| in_ready | output | 1 | Adapter accepts a byte at the next edge |
| in_sop | input | 1 | Byte is the first of a packet |
| in_eop | input | 1 | Byte is the last of a packet |
| in_err | input | 1 | Packet is bad (sampled with in_eop) |
| gmii_tx_en | output | 1 | GMII transmit enable |
| gmii_txd | output | 8 | GMII transmit data |
| gmii_tx_er | output | 1 | GMII transmit error |

## Verification
Every GMII result is due one cycle after the stream edge that caused it, and in_ready falls in the cycle after the final byte is taken. The driver sets inputs on the falling edge. At that same falling edge it pushes the expected byte and error bit into a queue, and only if in_ready shows that the byte will be taken at the next rising edge. The monitor pops and compares one entry at each later falling edge where gmii_tx_en is high, so each comparison lands in the cycle after acceptance. The monitor also counts the low cycles of gmii_tx_en between frames, and the driver counts the low cycles of in_ready after an end byte, to check the gap exactly.

// File: rtl/pgt_pkg.sv
package pgt_pkg;
   localparam int unsigned OCTET_W = 8;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_FRAME = 1'b1
   } ctl_state_e;

   typedef struct packed {
      logic               en;
      logic               err;
      logic [OCTET_W-1:0] data;
   } beat_t;
endpackage

// File: rtl/pgt_gap_timer.sv
module pgt_gap_timer #(
   parameter int unsigned GAP_CYCLES = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int unsigned CW = $clog2(GAP_CYCLES + 1);

   logic [CW-1:0] cnt;

   initial begin
      assert (GAP_CYCLES >= 2) else $error("pgt_gap_timer: GAP_CYCLES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (start)
         cnt <= CW'(GAP_CYCLES);
      else if (cnt != '0)
         cnt <= cnt - CW'(1);
   end

   assign busy = (cnt != '0);

   // R6: a started gap blocks input on the very next cycle
   a_r6_gap_loads: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
endmodule

// File: rtl/pgt_frame_ctrl.sv
module pgt_frame_ctrl
   import pgt_pkg::*;
#(
   parameter int unsigned         FILL_MODE = 0,
   parameter logic [OCTET_W-1:0]  FILL_BYTE = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [OCTET_W-1:0] in_data,
   input  logic               in_valid,
   input  logic               in_sop,
   input  logic               in_eop,
   input  logic               in_err,
   input  logic               gap_busy,
   output logic               in_ready,
   output logic               gap_start,
   output beat_t              nx_beat
);
   ctl_state_e         st, st_nx;
   logic               uflow, uflow_nx;
   logic               take;
   logic [OCTET_W-1:0] fill;

   initial begin
      assert (FILL_MODE <= 1) else $error("pgt_frame_ctrl: FILL_MODE must be 0 or 1");
   end

   generate
      if (FILL_MODE == 0) begin : g_fill_const
         assign fill = FILL_BYTE;
      end else begin : g_fill_repeat
         logic [OCTET_W-1:0] last_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               last_q <= FILL_BYTE;
            else if (nx_beat.en)
               last_q <= nx_beat.data;
         end
         assign fill = last_q;
      end
   endgenerate

   assign in_ready = !gap_busy;
   assign take     = in_valid && in_ready;

   always_comb begin
      st_nx     = st;
      uflow_nx  = uflow;
      gap_start = 1'b0;
      nx_beat   = '0;
      unique case (st)
         ST_IDLE: begin
            if (take && in_sop) begin
               nx_beat.en   = 1'b1;
               nx_beat.data = in_data;
               if (in_eop) begin
                  nx_beat.err = in_err;
                  gap_start   = 1'b1;
               end else begin
                  st_nx    = ST_FRAME;
                  uflow_nx = 1'b0;
               end
            end
         end
         ST_FRAME: begin
            nx_beat.en = 1'b1;
            if (take) begin
               nx_beat.data = in_data;
               if (in_sop) begin
                  nx_beat.err = 1'b1;
                  gap_start   = 1'b1;
                  st_nx       = ST_IDLE;
               end else if (in_eop) begin
                  nx_beat.err = in_err | uflow;
                  gap_start   = 1'b1;
                  st_nx       = ST_IDLE;
               end
            end else begin
               nx_beat.data = fill;
               uflow_nx     = 1'b1;
            end
         end
         default: st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         uflow <= 1'b0;
      end else begin
         st    <= st_nx;
         uflow <= uflow_nx;
      end
   end

   // R8: a start flag inside an open frame closes it and opens the gap
   a_r8_sop_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FRAME && take && in_sop) |=> gap_busy);

   // R6: no frame is ever open while the gap timer runs
   a_r6_no_frame_in_gap: assert property (@(posedge clk) disable iff (!rst_n)
      gap_busy |-> st == ST_IDLE);
endmodule

// File: rtl/pgt_out_stage.sv
module pgt_out_stage
   import pgt_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  beat_t              nx_beat,
   output logic               tx_en,
   output logic               tx_er,
   output logic [OCTET_W-1:0] txd
);
   beat_t q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else
         q <= nx_beat;
   end

   assign tx_en = q.en;
   assign tx_er = q.err;
   assign txd   = q.data;

   // R5: the error line is only raised inside a frame
   a_r5_err_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      tx_er |-> tx_en);

   // R5: the error is carried on the final byte, so the frame ends after it
   a_r5_err_on_last: assert property (@(posedge clk) disable iff (!rst_n)
      tx_er |=> !tx_en);
endmodule

// File: rtl/pgt_tx_adapter.sv
module pgt_tx_adapter #(
   parameter int unsigned GAP_CYCLES = 12,
   parameter int unsigned FILL_MODE  = 0,
   parameter logic [7:0]  FILL_BYTE  = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] in_data,
   input  logic       in_valid,
   output logic       in_ready,
   input  logic       in_sop,
   input  logic       in_eop,
   input  logic       in_err,
   output logic       gmii_tx_en,
   output logic [7:0] gmii_txd,
   output logic       gmii_tx_er
);
   import pgt_pkg::*;

   initial begin
      assert (OCTET_W == 8) else $error("pgt_tx_adapter: GMII data must be 8 bits");
   end

   beat_t nx_beat;
   logic  gap_start;
   logic  gap_busy;

   pgt_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
      .clk   (clk),
      .rst_n (rst_n),
      .start (gap_start),
      .busy  (gap_busy)
   );

   pgt_frame_ctrl #(.FILL_MODE(FILL_MODE), .FILL_BYTE(FILL_BYTE)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_data   (in_data),
      .in_valid  (in_valid),
      .in_sop    (in_sop),
      .in_eop    (in_eop),
      .in_err    (in_err),
      .gap_busy  (gap_busy),
      .in_ready  (in_ready),
      .gap_start (gap_start),
      .nx_beat   (nx_beat)
   );

   pgt_out_stage u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .nx_beat (nx_beat),
      .tx_en   (gmii_tx_en),
      .tx_er   (gmii_tx_er),
      .txd     (gmii_txd)
   );

   // R2: a frame's first byte is on the bus one cycle after it is taken
   a_r2_first_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_sop) |=> (gmii_tx_en && gmii_txd == $past(in_data)));

   // R3: enable only rises on a byte taken with its start flag
   a_r3_start_on_sop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gmii_tx_en) |-> $past(in_valid && in_ready && in_sop));

   // R6: when a frame ends on the line, input is already held off
   a_r6_ready_low_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gmii_tx_en) |-> !in_ready);
endmodule

// File: tb/pgt_tx_adapter_tb.sv
module pgt_tx_adapter_tb;
   localparam int GAP = 12;
   localparam logic [7:0] FILL = 8'h00;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] in_data = '0;
   logic       in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_err = 1'b0;
   logic       in_ready, gmii_tx_en, gmii_tx_er;
   logic [7:0] gmii_txd;

   int total = 0, bad = 0;
   logic [8:0] q[$];
   int low_cnt = 0, last_gap = -1;
   bit seen_frame = 0, prev_en = 0;

   always #2 clk = ~clk;

   pgt_tx_adapter u_dut (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
      .in_ready(in_ready), .in_sop(in_sop), .in_eop(in_eop), .in_err(in_err),
      .gmii_tx_en(gmii_tx_en), .gmii_txd(gmii_txd), .gmii_tx_er(gmii_tx_er)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // drive one byte; push expected output if it is to appear on the line
   task automatic put(input logic [7:0] d, input bit s, input bit e, input bit er,
                      input bit shows, input bit exp_err);
      @(negedge clk);
      in_data = d; in_sop = s; in_eop = e; in_err = er; in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      if (shows) q.push_back({exp_err, d});
   endtask

   // a stall inside an open frame (R7)
   task automatic hole();
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_err = 1'b0;
      q.push_back({1'b0, FILL});
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_err = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic frame(input int len, input logic [7:0] base, input bit er);
      for (int i = 0; i < len; i++)
         put(base + 8'(i), i == 0, i == len - 1, (i == len - 1) && er, 1'b1, (i == len - 1) && er);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (gmii_tx_er && !gmii_tx_en) chk(0, "R5", "tx_er outside frame", 1, 0);
         if (gmii_tx_en) begin
            if (q.size() == 0) chk(0, "R4", "unexpected byte on line", gmii_txd, 0);
            else begin
               logic [8:0] exp;
               exp = q.pop_front();
               chk(gmii_txd == exp[7:0], "R2", "txd", gmii_txd, exp[7:0]);
               chk(gmii_tx_er == exp[8], "R5", "tx_er", gmii_tx_er, exp[8]);
            end
            if (!prev_en && seen_frame) begin
               last_gap = low_cnt;
               chk(low_cnt >= GAP, "R6", "idle gap on line", low_cnt, GAP);
            end
            low_cnt = 0;
            seen_frame = 1;
         end else low_cnt++;
         prev_en = gmii_tx_en;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      chk(0, "WATCHDOG", "run did not finish", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(gmii_tx_en == 0, "R1", "tx_en after reset", gmii_tx_en, 0);
      chk(gmii_tx_er == 0, "R1", "tx_er after reset", gmii_tx_er, 0);
      chk(gmii_txd == 8'h00, "R1", "txd after reset", gmii_txd, 0);
      chk(in_ready == 1, "R1", "ready after reset", in_ready, 1);

      // R2 R3: clean frame, then back-to-back bad frame (R5, R6 exact gap)
      frame(5, 8'h10, 0);
      frame(4, 8'h40, 1);
      idle(3);
      chk(last_gap == GAP, "R6", "back-to-back gap", last_gap, GAP);

      // R9: one-byte frames, clean and bad
      frame(1, 8'hA5, 0);
      frame(1, 8'h5A, 1);
      idle(3);

      // R6: ready low for exactly GAP cycles after end byte
      frame(3, 8'h70, 0);
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
      n = 0;
      while (!in_ready) begin n++; @(negedge clk); end
      chk(n == GAP, "R6", "ready low cycles", n, GAP);

      // R4: bytes without start flag outside a frame are dropped
      put(8'hE1, 0, 0, 0, 0, 0);
      put(8'hE2, 0, 1, 1, 0, 0);
      put(8'hE3, 0, 0, 0, 0, 0);
      idle(2);
      chk(gmii_tx_en == 0, "R4", "tx_en after stray bytes", gmii_tx_en, 0);
      chk(q.size() == 0, "R4", "nothing pending", q.size(), 0);

      // R7: stalls inside a frame keep enable high, send fill, mark frame bad
      put(8'h20, 1, 0, 0, 1, 0);
      put(8'h21, 0, 0, 0, 1, 0);
      hole();
      hole();
      put(8'h22, 0, 0, 0, 1, 0);
      put(8'h23, 0, 1, 0, 1, 1);
      idle(2);

      // R8: start flag inside open frame ends it with error; rest dropped
      idle(GAP);
      put(8'h30, 1, 0, 0, 1, 0);
      put(8'h31, 0, 0, 0, 1, 0);
      put(8'h32, 0, 0, 0, 1, 0);
      put(8'h33, 1, 0, 0, 1, 1);
      put(8'h34, 0, 0, 0, 0, 0);
      put(8'h35, 0, 1, 0, 0, 0);
      idle(3);
      chk(gmii_tx_en == 0, "R8", "tx_en after dropped tail", gmii_tx_en, 0);

      // recovery frame after abort (R3)
      idle(GAP);
      frame(3, 8'h90, 0);
      idle(GAP + 4);
      chk(q.size() == 0, "R3", "all expected bytes sent", q.size(), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule